// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides which clocks of a small 8-bit controller core are allowed to run. Software picks between a light sleep (idle) and a deep sleep (power-down) by issuing a register write whose data carries one bit for each mode. In idle, only the processor clock is gated, so timers, the serial unit, interrupt logic and RAM keep running. In power-down, the oscillator enable is removed and the whole chip stops, while RAM keeps its contents.

An interrupt request that is enabled ends idle. Power-down ends only through a hardware reset. The block therefore also contains the reset qualifier. It synchronises the external reset pin and raises the internal core reset only after the pin has stayed high for two machine cycles of twelve oscillator periods each. While the chip is in power-down, a high pin immediately re-enables the oscillator so that the qualifier has a clock to count with. All state sits in plain static flip-flops, so it holds at any clock rate, including a stopped clock.

Top module: `pmc_power_ctrl`

## Requirements
- R1: After `por_n` is released, the block is in run mode: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1 and `core_rst` is 0.
- R2: In run mode, a clock edge with `wr_en`=1, `wr_idle`=1 and `wr_pd`=0 enters idle. From the next cycle, `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_en`=1.
- R3: In run mode, a clock edge with `wr_en`=1 and `wr_pd`=1 enters power-down. From the next cycle, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0 while `rst_pin` is 0.
- R4: When `wr_idle` and `wr_pd` are both 1 in the same write, power-down is entered.
- R5: A cycle with `wr_en`=0, or a write with both mode bits at 0, leaves the block in run mode.
- R6: In idle, any bit where `irq_req` and `irq_en` are both 1 returns the block to run mode on the next cycle (`cpu_clk_en`=1). A request whose enable bit is 0 has no effect.
- R7: In power-down, interrupt requests have no effect, enabled or not.
- R8: `core_rst` rises only after `rst_pin` has been high for HOLD_CYCLES (default 24) consecutive rising edges. It rises after edge number SYNC_STAGES+HOLD_CYCLES (default 26), counting the first edge that sees the pin high as edge 1. A shorter high pulse never asserts it, and a low sample restarts the count.
- R9: `core_rst` stays high while the pin stays high. It returns the block to run mode from idle or power-down, and it is the only way out of power-down.
- R10: In power-down, `osc_en` follows `rst_pin` high at once, with no clock edge needed.
- R11: Writes that arrive while the block is in idle or power-down are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| wr_en | input | 1 | Strobe for a write to the power control register |
| wr_idle | input | 1 | Write data bit that requests idle |
| wr_pd | input | 1 | Write data bit that requests power-down |
| irq_req | input | N_IRQ | Pending interrupt requests |
| irq_en | input | N_IRQ | Per-source interrupt enable bits |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Clock enable for peripherals, RAM and interrupt logic |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Qualified internal reset, active high |

## Verification
The assertions assume that `por_n` is applied once at power-up before any other activity, and that the write strobe and the interrupt inputs are stable around each rising edge. They also assume a real core would not issue writes while its own clock is gated. The stimulus changes every input only at the falling edge. It still issues writes during idle on purpose, to show that they are dropped. It holds the reset pin for exact edge counts just below and at the qualifying length.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_DOWN = 2'd2
   } pm_mode_e;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 24
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin,
   output logic core_rst
);
   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYCLES);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pmc_rst_qual: SYNC_STAGES must be at least 1");
      end
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("pmc_rst_qual: HOLD_CYCLES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) sync_q <= '0;
            else        sync_q <= pin;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         end
      end
   endgenerate

   assign pin_s = sync_q[SYNC_STAGES-1];

   // Run-length of consecutive high samples, saturating at the hold length
   logic [CNT_W-1:0] cnt_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              cnt_q <= '0;
      else if (!pin_s)         cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign core_rst = (cnt_q == CNT_MAX);

   // R8: a single low synchronised sample removes the qualified reset
   p_low_clears_r8: assert property (@(posedge clk) disable iff (!por_n)
      !pin_s |=> !core_rst);
   // R9: the reset holds while the synchronised pin stays high
   p_hold_stays_r9: assert property (@(posedge clk) disable iff (!por_n)
      core_rst && pin_s |=> core_rst);
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
   parameter int N_IRQ    = 5,
   parameter bit WAKE_REG = 1'b0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   output logic             wake
);
   generate
      if (N_IRQ < 1) begin : g_bad_irq
         $error("pmc_wake: N_IRQ must be at least 1");
      end
   endgenerate

   logic hit;
   assign hit = |(irq_req & irq_en);

   generate
      if (WAKE_REG) begin : g_wake_flop
         logic hit_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) hit_q <= 1'b0;
            else        hit_q <= hit;
         end
         assign wake = hit_q;
      end else begin : g_wake_comb
         assign wake = hit;
      end
   endgenerate
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
(
   input  logic     clk,
   input  logic     por_n,
   input  logic     core_rst,
   input  logic     wr_en,
   input  logic     wr_idle,
   input  logic     wr_pd,
   input  logic     wake,
   output pm_mode_e mode
);
   pm_mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (core_rst) begin
         mode_d = PM_RUN;
      end else begin
         unique case (mode_q)
            PM_RUN: begin
               if (wr_en && wr_pd)        mode_d = PM_DOWN;
               else if (wr_en && wr_idle) mode_d = PM_IDLE;
            end
            PM_IDLE: if (wake) mode_d = PM_RUN;
            PM_DOWN: mode_d = PM_DOWN;
            default: mode_d = PM_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) mode_q <= PM_RUN;
      else        mode_q <= mode_d;
   end

   assign mode = mode_q;

   // R2: an idle-only write from run enters idle
   p_idle_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
      mode_q == PM_RUN && wr_en && wr_idle && !wr_pd && !core_rst |=> mode_q == PM_IDLE);
   // R4: power-down wins when both bits arrive together
   p_both_bits_r4: assert property (@(posedge clk) disable iff (!por_n)
      mode_q == PM_RUN && wr_en && wr_idle && wr_pd && !core_rst |=> mode_q == PM_DOWN);
   // R6: a wake request ends idle on the next cycle
   p_idle_wake_r6: assert property (@(posedge clk) disable iff (!por_n)
      mode_q == PM_IDLE && wake && !core_rst |=> mode_q == PM_RUN);
   // R9: power-down is left only through the qualified reset
   p_pd_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
      mode_q == PM_DOWN && !core_rst |=> mode_q == PM_DOWN);
   // R9: the qualified reset forces run mode
   p_reset_run_r9: assert property (@(posedge clk) disable iff (!por_n)
      core_rst |=> mode_q == PM_RUN);
   // R11: writes while asleep change nothing
   p_sleep_write_r11: assert property (@(posedge clk) disable iff (!por_n)
      mode_q == PM_IDLE && wr_en && !wake && !core_rst |=> mode_q == PM_IDLE);
endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
   import pmc_pkg::*;
#(
   parameter int N_IRQ       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int MC_PERIODS  = 12,
   parameter int HOLD_MC     = 2,
   parameter bit WAKE_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_pin,
   input  logic             wr_en,
   input  logic             wr_idle,
   input  logic             wr_pd,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             osc_en,
   output logic             core_rst
);
   localparam int HOLD_CYCLES = MC_PERIODS * HOLD_MC;

   generate
      if (MC_PERIODS < 1 || HOLD_MC < 1) begin : g_bad_mc
         $error("pmc_power_ctrl: machine cycle length and hold count must be positive");
      end
   endgenerate

   logic     wake;
   pm_mode_e mode;

   pmc_rst_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .HOLD_CYCLES (HOLD_CYCLES)
   ) i_rst_qual (
      .clk      (clk),
      .por_n    (por_n),
      .pin      (rst_pin),
      .core_rst (core_rst)
   );

   pmc_wake #(
      .N_IRQ    (N_IRQ),
      .WAKE_REG (WAKE_REG)
   ) i_wake (
      .clk     (clk),
      .por_n   (por_n),
      .irq_req (irq_req),
      .irq_en  (irq_en),
      .wake    (wake)
   );

   pmc_mode_fsm i_fsm (
      .clk      (clk),
      .por_n    (por_n),
      .core_rst (core_rst),
      .wr_en    (wr_en),
      .wr_idle  (wr_idle),
      .wr_pd    (wr_pd),
      .wake     (wake),
      .mode     (mode)
   );

   assign cpu_clk_en = (mode == PM_RUN);
   assign per_clk_en = (mode != PM_DOWN);
   // A high pin restarts the oscillator so the qualifier can count
   assign osc_en     = (mode != PM_DOWN) || rst_pin;

   // R10: the reset pin always has a running oscillator
   p_osc_restart_r10: assert property (@(posedge clk) disable iff (!por_n)
      rst_pin |-> osc_en);
   // R3: the processor never runs without the peripheral clock
   p_clock_nesting_r3: assert property (@(posedge clk) disable iff (!por_n)
      cpu_clk_en |-> per_clk_en && osc_en);
endmodule

// File: tb/test_pmc_power_ctrl.sv
module test_pmc_power_ctrl;
   localparam int N_IRQ = 5;

   logic             clk = 1'b0;
   logic             por_n = 1'b0;
   logic             rst_pin = 1'b0;
   logic             wr_en = 1'b0, wr_idle = 1'b0, wr_pd = 1'b0;
   logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
   logic             cpu_clk_en, per_clk_en, osc_en, core_rst;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   pmc_power_ctrl #(.N_IRQ(N_IRQ)) i_pmc_power_ctrl (
      .clk(clk), .por_n(por_n), .rst_pin(rst_pin),
      .wr_en(wr_en), .wr_idle(wr_idle), .wr_pd(wr_pd),
      .irq_req(irq_req), .irq_en(irq_en),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .osc_en(osc_en), .core_rst(core_rst)
   );

   // Vector fields: wr_en, wr_idle, wr_pd | expected cpu, per, osc
   localparam int NV = 6;
   localparam logic [5:0] VEC [NV] = '{
      6'b110_011,   // R2 idle only
      6'b101_000,   // R3 power-down only
      6'b111_000,   // R4 both bits
      6'b011_111,   // R5 no strobe
      6'b100_111,   // R5 strobe with empty data
      6'b010_111    // R5 idle bit without strobe
   };

   function automatic string vreq(int i);
      case (i)
         0:       return "R2";
         1:       return "R3";
         2:       return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(string req, string what, logic got, logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic step(int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic power_on();
      @(negedge clk);
      por_n = 1'b0;
      wr_en = 0; wr_idle = 0; wr_pd = 0; irq_req = '0; irq_en = '0; rst_pin = 0;
      step(2);
      por_n = 1'b1;
      step(1);
   endtask

   task automatic write(logic idle_b, logic pd_b);
      wr_en = 1; wr_idle = idle_b; wr_pd = pd_b;
      step(1);
      wr_en = 0; wr_idle = 0; wr_pd = 0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int seen;

      // R1 reset state
      power_on();
      chk("R1", "cpu_clk_en", cpu_clk_en, 1'b1);
      chk("R1", "per_clk_en", per_clk_en, 1'b1);
      chk("R1", "osc_en", osc_en, 1'b1);
      chk("R1", "core_rst", core_rst, 1'b0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         power_on();
         wr_en = VEC[i][5]; wr_idle = VEC[i][4]; wr_pd = VEC[i][3];
         step(1);
         wr_en = 0; wr_idle = 0; wr_pd = 0;
         chk(vreq(i), "cpu_clk_en", cpu_clk_en, VEC[i][2]);
         chk(vreq(i), "per_clk_en", per_clk_en, VEC[i][1]);
         chk(vreq(i), "osc_en", osc_en, VEC[i][0]);
      end

      // R6 masked request ignored, enabled request wakes
      power_on();
      write(1, 0);
      irq_req = 5'b00100; irq_en = 5'b11011;
      step(1);
      chk("R6", "cpu_clk_en masked", cpu_clk_en, 1'b0);
      irq_en = 5'b00100;
      step(1);
      chk("R6", "cpu_clk_en enabled", cpu_clk_en, 1'b1);
      irq_req = '0; irq_en = '0;

      // R11 power-down write during idle dropped
      write(1, 0);
      write(0, 1);
      chk("R11", "per_clk_en", per_clk_en, 1'b1);
      chk("R11", "cpu_clk_en", cpu_clk_en, 1'b0);

      // R7 interrupts ignored in power-down
      power_on();
      write(0, 1);
      irq_req = '1; irq_en = '1;
      step(3);
      chk("R7", "cpu_clk_en", cpu_clk_en, 1'b0);
      chk("R7", "per_clk_en", per_clk_en, 1'b0);
      irq_req = '0; irq_en = '0;

      // R10 pin restarts oscillator without a clock edge
      rst_pin = 1'b1;
      #1;
      chk("R10", "osc_en", osc_en, 1'b1);
      @(negedge clk);
      rst_pin = 1'b0;
      step(4);

      // R8 a 23-edge pulse is too short
      rst_pin = 1'b1;
      step(23);
      rst_pin = 1'b0;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
         step(1);
         if (core_rst) seen = 1;
      end
      chk("R8", "core_rst short pulse", seen[0], 1'b0);
      chk("R9", "per_clk_en still down", per_clk_en, 1'b0);

      // R8 exact qualifying time
      rst_pin = 1'b1;
      step(25);
      chk("R8", "core_rst after 25 edges", core_rst, 1'b0);
      step(1);
      chk("R8", "core_rst after 26 edges", core_rst, 1'b1);
      step(6);
      chk("R9", "core_rst while held", core_rst, 1'b1);
      rst_pin = 1'b0;
      step(4);
      chk("R9", "core_rst released", core_rst, 1'b0);
      chk("R9", "cpu_clk_en after exit", cpu_clk_en, 1'b1);
      chk("R9", "per_clk_en after exit", per_clk_en, 1'b1);

      // R8 a low sample restarts the count
      write(1, 0);
      rst_pin = 1'b1;
      step(20);
      rst_pin = 1'b0;
      step(1);
      rst_pin = 1'b1;
      step(20);
      chk("R8", "core_rst after split pulse", core_rst, 1'b0);
      chk("R8", "cpu_clk_en idle kept", cpu_clk_en, 1'b0);
      step(6);
      chk("R9", "core_rst from idle", core_rst, 1'b1);
      rst_pin = 1'b0;
      step(4);
      chk("R9", "cpu_clk_en idle exit", cpu_clk_en, 1'b1);

      finish_run();
   end
endmodule